// File: doc/BRIEF.md
# Sticky Fault Status and Alert Masking Controller

This block gathers per-source out-of-limit levels from a hardware monitor into sticky status bits. The sources are three temperature channels, two supply channels, two diode error flags, four fan failures and an over-temperature flag. A status bit stays set until the host reads it and the fault has gone. Two mask registers decide which set bits may pull an active-low alert low. Masking only gates the alert. It never stops a status bit from being set.

The alert does not have a pin of its own. It leaves the block through one multiplexed pin, whose function a two-bit configuration field selects. The pin can serve as a fan tachometer input, an active-low thermal input, the alert output, or a general-purpose pin. When the pin is selected as the thermal input and that input is enabled, a low level on the pin sets the status bit that otherwise reports the fourth fan. A simple register port gives the host clear-on-read access to both status registers. Through the same port it writes the masks and the two configuration registers.

Top module: `alert_status_ctrl`

## Requirements
- R1: After reset, both masks and both configuration registers read 0, all status bits are clear, and the pin is not driven (pinOe=0, pinOut=1), so the alert is disabled.
- R2: A high level on a fault input at a clock edge sets its status bit at that edge. The bit stays set after the input returns low, until it is cleared by a read. Status 1 bits: 0 supply A, 2 supply B, 4 remote 1, 5 local, 6 remote 2. Status 2 bits: 1 over-temperature, 2..5 fans 1..4, 6 diode 1, 7 diode 2. faultA and faultB map bit for bit onto these, and the other input bits are ignored.
- R3: A read (regRd=1) returns the register on regRdata one cycle later, and regRdata is 0 in every cycle that follows no read. Reading a status register clears its bits, except those whose fault input is high in the read cycle, which stay set.
- R4: A mask bit of 1 suppresses the alert for its source, and the status bit is still set normally.
- R5: With function field 2'b10 the pin is driven (pinOe=1), and pinOut is low exactly while some set status bit is unmasked. pinOut returns high in the cycle after every set bit becomes masked. With any other function, pinOe=0 and pinOut=1.
- R6: Status 1 bit 7 reads as the OR of all status 2 bits, and reading status 1 does not clear status 2. Mask 1 bit 7 masks the alert from every status 2 bit.
- R7: With the function field at 2'b01 and configuration 3 bit 1 set, pinIn is synchronised through two flops. A low level then sets status 2 bit 5 two edges after it is first sampled, and faultB bit 5 is ignored. Otherwise status 2 bit 5 follows faultB bit 5.
- R8: Address map: status 1 0x41, status 2 0x42, mask 1 0x74, mask 2 0x75, configuration 3 0x78, configuration 4 0x7D (function field in bits [1:0]). Only implemented bits store: mask 1 keeps 0xF5, mask 2 keeps 0xFE, configuration 3 keeps 0x02 and configuration 4 keeps 0x03. Writes to status registers are ignored, and unimplemented addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultA | input | 8 | Out-of-limit levels for status 1 sources |
| faultB | input | 8 | Out-of-limit levels for status 2 sources |
| regAddr | input | 8 | Register address |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRd | input | 1 | Read strobe, clears status on read |
| regRdata | output | 8 | Read data, one cycle after regRd |
| pinIn | input | 1 | Level seen on the multiplexed pin |
| pinOut | output | 1 | Value driven on the multiplexed pin (active-low alert) |
| pinOe | output | 1 | Drive enable of the multiplexed pin |

## Verification
Status bits and the alert pin move at the edge that samples a fault input, and read data appears on the edge after the read strobe. A thermal pin event reaches status only on the third edge after the pin changes, because of the two-flop synchroniser. The bench drives inputs on falling edges and samples 1 ns after each rising edge. Its reference model delays the pin through a two-entry queue and computes the read value from the state held before the edge. Directed reads add hand-computed values for each corner case: a fault held through a clearing read, a masked source, the status 2 summary, and the thermal substitution.

// File: rtl/alert_status_pkg.sv
package alert_status_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_ST1  = 8'h41;
  localparam logic [ADDR_W-1:0] ADDR_ST2  = 8'h42;
  localparam logic [ADDR_W-1:0] ADDR_MSK1 = 8'h74;
  localparam logic [ADDR_W-1:0] ADDR_MSK2 = 8'h75;
  localparam logic [ADDR_W-1:0] ADDR_CFG3 = 8'h78;
  localparam logic [ADDR_W-1:0] ADDR_CFG4 = 8'h7D;

  // implemented-bit patterns
  localparam logic [REG_W-1:0] ST1_IMPL  = 8'h75;
  localparam logic [REG_W-1:0] ST2_IMPL  = 8'hFE;
  localparam logic [REG_W-1:0] MSK1_IMPL = 8'hF5;
  localparam logic [REG_W-1:0] MSK2_IMPL = 8'hFE;
  localparam logic [REG_W-1:0] CFG3_IMPL = 8'h02;

  localparam int SUM_BIT      = 7;
  localparam int FAN4_BIT     = 5;
  localparam int THERM_EN_BIT = 1;

  typedef enum logic [1:0] {
    PIN_TACH  = 2'b00,
    PIN_THERM = 2'b01,
    PIN_ALERT = 2'b10,
    PIN_GPIO  = 2'b11
  } pinFunc_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_ST1, RD_ST2, RD_MSK1, RD_MSK2, RD_CFG3, RD_CFG4
  } rdSel_e;

  typedef struct packed {
    logic   wrMsk1;
    logic   wrMsk2;
    logic   wrCfg3;
    logic   wrCfg4;
    logic   clrSt1;
    logic   clrSt2;
    rdSel_e rdSel;
  } regStb_t;
endpackage

// File: rtl/alert_status_dec.sv
module alert_status_dec
  import alert_status_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output regStb_t           stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (regWr) begin
      unique case (regAddr)
        ADDR_MSK1: stb.wrMsk1 = 1'b1;
        ADDR_MSK2: stb.wrMsk2 = 1'b1;
        ADDR_CFG3: stb.wrCfg3 = 1'b1;
        ADDR_CFG4: stb.wrCfg4 = 1'b1;
        default: ;
      endcase
    end
    if (regRd) begin
      unique case (regAddr)
        ADDR_ST1:  begin stb.rdSel = RD_ST1; stb.clrSt1 = 1'b1; end
        ADDR_ST2:  begin stb.rdSel = RD_ST2; stb.clrSt2 = 1'b1; end
        ADDR_MSK1: stb.rdSel = RD_MSK1;
        ADDR_MSK2: stb.rdSel = RD_MSK2;
        ADDR_CFG3: stb.rdSel = RD_CFG3;
        ADDR_CFG4: stb.rdSel = RD_CFG4;
        default:   stb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/alert_status_sync.sv
module alert_status_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[i] <= RST_VAL;
        else       chain[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[i] <= RST_VAL;
        else       chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/alert_status_dp.sv
module alert_status_dp
  import alert_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStb_t          stb,
  input  logic [REG_W-1:0] regWdata,
  input  logic [REG_W-1:0] faultA,
  input  logic [REG_W-1:0] faultB,
  input  logic             pinSync,
  output logic [REG_W-1:0] regRdata,
  output logic [REG_W-1:0] st1Q,
  output logic [REG_W-1:0] st2Q,
  output logic [REG_W-1:0] m1Q,
  output logic [REG_W-1:0] m2Q,
  output logic             pinOut,
  output logic             pinOe
);
  logic [REG_W-1:0] st1, st2, m1, m2, cfg3;
  pinFunc_e         func;
  logic             thermOn;
  logic [REG_W-1:0] srcA, srcB, st1View, rdNext;
  logic             alertReq;

  assign thermOn = (func == PIN_THERM) && cfg3[THERM_EN_BIT];
  assign srcA    = faultA & ST1_IMPL;

  always_comb begin
    srcB = faultB & ST2_IMPL;
    if (thermOn) srcB[FAN4_BIT] = ~pinSync;
  end

  // sticky status, a live fault survives a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st1 <= '0;
      st2 <= '0;
    end else begin
      st1 <= srcA | (stb.clrSt1 ? '0 : st1);
      st2 <= srcB | (stb.clrSt2 ? '0 : st2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1   <= '0;
      m2   <= '0;
      cfg3 <= '0;
      func <= PIN_TACH;
    end else begin
      if (stb.wrMsk1) m1   <= regWdata & MSK1_IMPL;
      if (stb.wrMsk2) m2   <= regWdata & MSK2_IMPL;
      if (stb.wrCfg3) cfg3 <= regWdata & CFG3_IMPL;
      if (stb.wrCfg4) func <= pinFunc_e'(regWdata[1:0]);
    end
  end

  always_comb begin
    st1View = st1;
    st1View[SUM_BIT] = |st2;
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_ST1:  rdNext = st1View;
      RD_ST2:  rdNext = st2;
      RD_MSK1: rdNext = m1;
      RD_MSK2: rdNext = m2;
      RD_CFG3: rdNext = cfg3;
      RD_CFG4: rdNext = {6'b0, func};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) regRdata <= '0;
    else       regRdata <= rdNext;

  assign alertReq = (|(st1[SUM_BIT-1:0] & ~m1[SUM_BIT-1:0]))
                  | ((|(st2 & ~m2)) & ~m1[SUM_BIT]);

  assign pinOe  = (func == PIN_ALERT);
  assign pinOut = pinOe ? ~alertReq : 1'b1;

  assign st1Q = st1;
  assign st2Q = st2;
  assign m1Q  = m1;
  assign m2Q  = m2;
endmodule

// File: rtl/alert_status_ctrl.sv
module alert_status_ctrl
  import alert_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  faultA,
  input  logic [REG_W-1:0]  faultB,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              regRd,
  output logic [REG_W-1:0]  regRdata,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              pinOe
);
  regStb_t          stb;
  logic             pinSync;
  logic [REG_W-1:0] st1Q, st2Q, m1Q, m2Q;

  alert_status_dec u_dec (
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .stb(stb)
  );

  alert_status_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rstN(rstN), .din(pinIn), .dout(pinSync)
  );

  alert_status_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata),
    .faultA(faultA), .faultB(faultB), .pinSync(pinSync),
    .regRdata(regRdata), .st1Q(st1Q), .st2Q(st2Q), .m1Q(m1Q), .m2Q(m2Q),
    .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/alert_status_chk.sv
module alert_status_chk
  import alert_status_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regRd,
  input logic [REG_W-1:0] regRdata,
  input logic [REG_W-1:0] faultA,
  input logic [REG_W-1:0] faultB,
  input logic [REG_W-1:0] st1,
  input logic [REG_W-1:0] st2,
  input logic [REG_W-1:0] m1,
  input logic [REG_W-1:0] m2,
  input logic             clrSt1,
  input logic             clrSt2,
  input logic             pinOe,
  input logic             pinOut
);
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clrSt1 && !clrSt2) |=> (((st1 & $past(st1)) == $past(st1)) &&
                              ((st2 & $past(st2)) == $past(st2))));

  // R4
  mask_keeps_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((faultA != 0) || (faultB != 0)) |=>
      (((st1 & $past(faultA & ST1_IMPL)) == $past(faultA & ST1_IMPL)) &&
       ((st2 & $past(faultB & 8'hDE)) == $past(faultB & 8'hDE))));

  // R3
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> (regRdata == '0));

  // R5
  pin_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pinOe || (st1 == 0 && st2 == 0)) |-> pinOut);

  // R6
  summary_alert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && st2 != 0 && !m1[7] && m2 == 0) |-> !pinOut);
endmodule

bind alert_status_ctrl alert_status_chk u_chk (
  .clk(clk), .rstN(rstN), .regRd(regRd), .regRdata(regRdata),
  .faultA(faultA), .faultB(faultB), .st1(st1Q), .st2(st2Q),
  .m1(m1Q), .m2(m2Q), .clrSt1(stb.clrSt1), .clrSt2(stb.clrSt2),
  .pinOe(pinOe), .pinOut(pinOut)
);

// File: tb/alert_status_ctrl_tb.sv
`timescale 1ns/1ps
module alert_status_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] faultA = 0, faultB = 0, regAddr = 0, regWdata = 0;
  logic       regWr = 0, regRd = 0, pinIn = 1'b1;
  logic [7:0] regRdata;
  logic       pinOut, pinOe;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alert_status_ctrl u_dut (
    .clk(clk), .rstN(rstN), .faultA(faultA), .faultB(faultB),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata), .regRd(regRd),
    .regRdata(regRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit [7:0] mM1, mM2, mC3, mC4, mS1, mS2, expRd;
  bit       pinQ[$];

  always @(posedge clk) begin : mdl
    bit [7:0] view1, fb;
    bit       therm, oldPin;
    if (!rstN) begin
      mM1 = 0; mM2 = 0; mC3 = 0; mC4 = 0; mS1 = 0; mS2 = 0; expRd = 0;
      pinQ = {1'b1, 1'b1};
    end else begin
      view1 = mS1 | ((mS2 != 0) ? 8'h80 : 8'h00);
      expRd = 0;
      if (regRd)
        case (regAddr)
          8'h41: expRd = view1;
          8'h42: expRd = mS2;
          8'h74: expRd = mM1;
          8'h75: expRd = mM2;
          8'h78: expRd = mC3;
          8'h7D: expRd = mC4;
          default: expRd = 0;
        endcase
      therm  = (mC4 == 8'd1) && mC3[1];
      oldPin = pinQ.pop_back();
      pinQ.push_front(pinIn);
      fb = faultB & 8'hFE;
      if (therm) fb[5] = !oldPin;
      mS1 = (faultA & 8'h75) | ((regRd && regAddr == 8'h41) ? 8'h00 : mS1);
      mS2 = fb | ((regRd && regAddr == 8'h42) ? 8'h00 : mS2);
      if (regWr)
        case (regAddr)
          8'h74: mM1 = regWdata & 8'hF5;
          8'h75: mM2 = regWdata & 8'hFE;
          8'h78: mC3 = regWdata & 8'h02;
          8'h7D: mC4 = regWdata & 8'h03;
          default: ;
        endcase
    end
  end

  always @(posedge clk) begin : cmp
    bit alert, eOe;
    #1;
    if (rstN && !done) begin
      alert = ((mS1 & ~mM1 & 8'h7F) != 0) || (((mS2 & ~mM2) != 0) && !mM1[7]);
      eOe = (mC4 == 8'd2);
      chk("R5 model pinOe", {7'b0, pinOe}, {7'b0, eOe});
      chk("R5 model pinOut", {7'b0, pinOut}, {7'b0, eOe ? !alert : 1'b1});
      chk("R3 model regRdata", regRdata, expRd);
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rdExp(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); regAddr = a; regRd = 1;
    @(posedge clk); #1 chk(tag, regRdata, exp);
    @(negedge clk); regRd = 0;
  endtask

  task automatic pulseA(logic [7:0] v);
    @(negedge clk); faultA = v;
    @(negedge clk); faultA = 0;
  endtask

  task automatic pinChk(string tag, logic oe, logic o);
    @(negedge clk);
    chk({tag, " oe"}, {7'b0, pinOe}, {7'b0, oe});
    chk({tag, " out"}, {7'b0, pinOut}, {7'b0, o});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    pinChk("R1 reset pin", 0, 1);
    rdExp(8'h74, 8'h00, "R1 mask1 reset");
    rdExp(8'h75, 8'h00, "R1 mask2 reset");
    rdExp(8'h78, 8'h00, "R1 cfg3 reset");
    rdExp(8'h7D, 8'h00, "R1 cfg4 reset");
    rdExp(8'h41, 8'h00, "R1 status1 reset");
    // R8 implemented bits, unimplemented address
    wr(8'h74, 8'hFF); rdExp(8'h74, 8'hF5, "R8 mask1 bits");
    wr(8'h75, 8'hFF); rdExp(8'h75, 8'hFE, "R8 mask2 bits");
    wr(8'h78, 8'hFF); rdExp(8'h78, 8'h02, "R8 cfg3 bits");
    wr(8'h7D, 8'hFF); rdExp(8'h7D, 8'h03, "R8 cfg4 bits");
    wr(8'h10, 8'hAA); rdExp(8'h10, 8'h00, "R8 unimplemented read");
    wr(8'h74, 0); wr(8'h75, 0); wr(8'h78, 0); wr(8'h7D, 8'h02);
    pinChk("R5 alert idle", 1, 1);
    // R2 sticky, R5 alert
    pulseA(8'h10);
    pinChk("R5 alert asserted", 1, 0);
    rdExp(8'h41, 8'h10, "R2 sticky remote1");
    rdExp(8'h41, 8'h00, "R3 cleared on read");
    pinChk("R5 alert rearmed", 1, 1);
    // R3 fault held through read; ignored input bits
    @(negedge clk); faultA = 8'h0B;
    rdExp(8'h41, 8'h01, "R2 supplyA only");
    rdExp(8'h41, 8'h01, "R3 held fault survives read");
    @(negedge clk); faultA = 0;
    rdExp(8'h41, 8'h01, "R3 last read after drop");
    rdExp(8'h41, 8'h00, "R3 now clear");
    // R4 masking
    wr(8'h74, 8'h20);
    pulseA(8'h20);
    pinChk("R4 masked no alert", 1, 1);
    rdExp(8'h41, 8'h20, "R4 status still set");
    wr(8'h74, 8'h00);
    // R6 summary bit
    @(negedge clk); faultB = 8'h04;
    @(negedge clk); faultB = 0;
    pinChk("R6 status2 alert", 1, 0);
    rdExp(8'h41, 8'h80, "R6 summary bit");
    wr(8'h74, 8'h80);
    pinChk("R6 summary masked", 1, 1);
    rdExp(8'h42, 8'h04, "R6 status2 kept");
    rdExp(8'h41, 8'h00, "R6 summary cleared");
    wr(8'h74, 8'h00);
    // R5 masking after the fact deasserts
    pulseA(8'h40);
    pinChk("R5 pre mask", 1, 0);
    wr(8'h74, 8'h40);
    pinChk("R5 masked deassert", 1, 1);
    // R8 status writes ignored
    wr(8'h41, 8'h00); wr(8'h42, 8'hFF);
    rdExp(8'h41, 8'h40, "R8 status1 write ignored");
    rdExp(8'h42, 8'h00, "R8 status2 write ignored");
    wr(8'h74, 8'h00);
    // R7 thermal input
    wr(8'h7D, 8'h01);
    pinChk("R5 thermal mode pin", 0, 1);
    @(negedge clk); pinIn = 0;
    repeat (2) @(negedge clk); pinIn = 1;
    repeat (3) @(negedge clk);
    rdExp(8'h42, 8'h00, "R7 pin ignored while disabled");
    wr(8'h78, 8'h02);
    @(negedge clk); faultB = 8'h20;
    repeat (3) @(negedge clk); faultB = 0;
    rdExp(8'h42, 8'h00, "R7 fan4 ignored in thermal mode");
    @(negedge clk); pinIn = 0;
    @(negedge clk); pinIn = 1;
    repeat (3) @(negedge clk);
    rdExp(8'h42, 8'h20, "R7 thermal event");
    rdExp(8'h42, 8'h00, "R7 thermal cleared");
    wr(8'h78, 8'h00);
    @(negedge clk); faultB = 8'h20;
    @(negedge clk); faultB = 0;
    rdExp(8'h42, 8'h20, "R7 fan4 when thermal disabled");
    // R5 alert disabled in tach mode with status set
    wr(8'h7D, 8'h00);
    pulseA(8'h04);
    pinChk("R5 tach mode undriven", 0, 1);
    rdExp(8'h41, 8'h04, "R2 supplyB sticky");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end
endmodule